// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block gathers ninety-six level-sensitive interrupt sources, grouped as three 32-bit banks, and drives one interrupt request line toward a processor. Each bank holds an enable mask. Software never writes a mask directly. One address per bank turns enables on for every bit written as 1, and a different address per bank turns them off in the same way. Software can therefore change one source's enable without a read-modify-write sequence.

For each bank, software can read a pending word, which is the live source levels ANDed with that bank's enables. The pending word of the base bank also carries two summary bits, one for each of the other two banks. A handler can read that single word to learn which bank needs attention, then search the chosen bank's pending word for its lowest set bit. The request output is registered and rises one clock after any enabled source is high. Access is through a simple 32-bit synchronous bus: a read returns its data on the clock after the request.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, every enable bit, `irq_o` and `bus_rdata` are 0.
- R2: A write to the enable-set address of a bank sets that bank's enable for every 1 bit in `bus_wdata` and leaves the others unchanged. The addresses are 0x10 for bank 1, 0x14 for bank 2 and 0x18 for the base bank 0. The change is visible from the next clock.
- R3: A write to the enable-clear address of a bank clears that bank's enable for every 1 bit in `bus_wdata` and leaves the others unchanged. The addresses are 0x1C for bank 1, 0x20 for bank 2 and 0x24 for bank 0. Writing all ones to all three leaves every source masked.
- R4: A read of 0x04 returns the bank 1 source levels ANDed with the bank 1 enables. A read of 0x08 does the same for bank 2. The data appears on `bus_rdata` on the clock after the read request and is held until the next read.
- R5: A read of 0x00 returns the bank 0 source levels ANDed with the bank 0 enables, except for two summary bits. Bit 8 is 1 when any enabled bank 1 source is high, and bit 9 is 1 when any enabled bank 2 source is high.
- R6: Bank 0 source inputs 8 and 9 have no effect on the 0x00 read data or on `irq_o`, whatever their enables.
- R7: `irq_o` is 1 exactly one clock after a cycle in which any enabled source is high, counting bank 1, bank 2 and bank 0 except bits 8 and 9. Otherwise it is 0.
- R8: A read of a bank's enable-set or enable-clear address returns that bank's current enable mask.
- R9: Reads of 0x0C and of unused addresses (0x28 and above) return 0. Writes to 0x00 through 0x0C and to unused addresses change no enable. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 for a write and 0 for a read, while bus_sel is 1 |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the clock after a read |
| src_i | input | 96 | Source levels: bits 31:0 are bank 0, bits 63:32 are bank 1, bits 95:64 are bank 2 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a base pending word in which the summary bits and the ignored bank 0 inputs 8 and 9 disagree. For that, bank 0 is fully enabled, only inputs 8 and 9 are driven high, and the other banks are toggled between empty and non-empty. Mask writes are also issued in the same cycle as a source change and read back straight away, so that the one-clock gap between an enable update and the request output is exercised. Long random runs mix set, clear, pending and mask reads against the behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NBANK    = 3;
  localparam int unsigned WI_PEND0 = 0;
  localparam int unsigned WI_PEND1 = 1;
  localparam int unsigned WI_PEND2 = 2;
  localparam int unsigned WI_FAST  = 3;
  localparam int unsigned WI_CLR_OFFSET = 3;

  // word index of the enable-set register that controls bank b
  function automatic int unsigned set_word(int unsigned b);
    return (b == 0) ? 6 : 3 + b;
  endfunction

  // word index of the enable-clear register that controls bank b
  function automatic int unsigned clr_word(int unsigned b);
    return set_word(b) + WI_CLR_OFFSET;
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned    W      = 32,
  parameter logic [W-1:0]   IGNORE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend,
  output logic         any
);
  logic [W-1:0] en_d;
  logic         en_upd;

  always_comb begin
    en_upd = set_we | clr_we;
    en_d   = en_q;
    if (set_we)      en_d = en_q | wdata;
    else if (clr_we) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  assign pend = src & en_q & ~IGNORE;
  assign any  = |pend;
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned S1 = 8,
  parameter int unsigned S2 = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [AW-1:0]         addr,
  input  logic [NBANK-1:0][W-1:0] en,
  input  logic [NBANK-1:0][W-1:0] pend,
  input  logic [NBANK-1:0]      any,
  output logic [NBANK-1:0]      set_we,
  output logic [NBANK-1:0]      clr_we,
  output logic [W-1:0]          rdata
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          rd_en;
  logic [W-1:0]  rd_d;
  logic [W-1:0]  rd_q;

  assign idx   = addr[AW-1:2];
  assign rd_en = sel & ~wr;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign set_we[b] = sel & wr & (idx == IW'(set_word(b)));
    assign clr_we[b] = sel & wr & (idx == IW'(clr_word(b)));
  end

  always_comb begin
    rd_d = '0;
    if (idx == IW'(WI_PEND0)) begin
      rd_d     = pend[0];
      rd_d[S1] = any[1];
      rd_d[S2] = any[2];
    end else if (idx == IW'(WI_PEND1)) begin
      rd_d = pend[1];
    end else if (idx == IW'(WI_PEND2)) begin
      rd_d = pend[2];
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (idx == IW'(set_word(b)) || idx == IW'(clr_word(b))) rd_d = en[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SUM1_POS = 8,
  parameter int unsigned SUM2_POS = 9,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [NBANK*DATA_W-1:0] src_i,
  output logic                    irq_o
);
  localparam logic [DATA_W-1:0] SUM_MASK =
    (DATA_W'(1) << SUM1_POS) | (DATA_W'(1) << SUM2_POS);

  logic                        rst_core_n;
  logic [NBANK-1:0][DATA_W-1:0] en_all;
  logic [NBANK-1:0][DATA_W-1:0] pend_all;
  logic [NBANK-1:0]            any_all;
  logic [NBANK-1:0]            set_we;
  logic [NBANK-1:0]            clr_we;
  logic                        irq_d;
  logic                        irq_q;

  irqc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [DATA_W-1:0] IGN = (b == 0) ? SUM_MASK : '0;
    irqc_bank #(.W(DATA_W), .IGNORE(IGN)) u_bank (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .set_we (set_we[b]),
      .clr_we (clr_we[b]),
      .wdata  (bus_wdata),
      .src    (src_i[b*DATA_W +: DATA_W]),
      .en_q   (en_all[b]),
      .pend   (pend_all[b]),
      .any    (any_all[b])
    );
  end

  irqc_regif #(.W(DATA_W), .AW(ADDR_W), .S1(SUM1_POS), .S2(SUM2_POS)) u_regif (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .en     (en_all),
    .pend   (pend_all),
    .any    (any_all),
    .set_we (set_we),
    .clr_we (clr_we),
    .rdata  (bus_rdata)
  );

  always_comb begin
    irq_d = |any_all;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  parameter int unsigned S1 = 8,
  parameter int unsigned S2 = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [3*DW-1:0]    src_i,
  input logic               irq_o,
  input logic [2:0][DW-1:0] en_all
);
  localparam logic [DW-1:0] SMASK = (DW'(1) << S1) | (DW'(1) << S2);
  logic [AW-3:0] idx;
  assign idx = bus_addr[AW-1:2];

  // R2: set write on bank 1 ORs the data into the mask
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && idx == 4) |=> en_all[1] == ($past(en_all[1]) | $past(bus_wdata)));

  // R3: clear write on bank 0 removes the written ones
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && idx == 9) |=> en_all[0] == ($past(en_all[0]) & ~$past(bus_wdata)));

  // R9: without a write the masks do not move
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(en_all));

  // R9: the fast control word reads zero
  p_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && idx == 3) |=> bus_rdata == '0);

  // R5: bank 2 summary bit in the base pending word
  p_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && idx == 0) |=> bus_rdata[S2] == $past(|(src_i[3*DW-1:2*DW] & en_all[2])));

  // R7, R6: request follows enabled sources one clock later
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past((|(src_i[DW-1:0] & en_all[0] & ~SMASK)) |
                            (|(src_i[2*DW-1:DW] & en_all[1])) |
                            (|(src_i[3*DW-1:2*DW] & en_all[2]))));
endmodule

bind irq_bank_ctrl irqc_checks #(.DW(DATA_W), .AW(ADDR_W), .S1(SUM1_POS), .S2(SUM2_POS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .src_i     (src_i),
  .irq_o     (irq_o),
  .en_all    (en_all)
);

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] src_i = '0;
  logic        irq_o;

  int    checks = 0;
  int    errors = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_en [3];
  logic        m_irq;
  logic [31:0] m_rd;

  irq_bank_ctrl i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] m_pend(int b);
    logic [31:0] p;
    p = src_i[b*32 +: 32] & m_en[b];
    if (b == 0) begin
      p[8] = |(src_i[63:32] & m_en[1]);
      p[9] = |(src_i[95:64] & m_en[2]);
    end
    return p;
  endfunction

  function automatic logic m_req();
    logic [31:0] p0;
    p0 = src_i[31:0] & m_en[0];
    p0[8] = 1'b0;
    p0[9] = 1'b0;
    return (|p0) | (|(src_i[63:32] & m_en[1])) | (|(src_i[95:64] & m_en[2]));
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a[7:2])
      6'd0: return m_pend(0);
      6'd1: return m_pend(1);
      6'd2: return m_pend(2);
      6'd4, 6'd7: return m_en[1];
      6'd5, 6'd8: return m_en[2];
      6'd6, 6'd9: return m_en[0];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en[0] <= '0; m_en[1] <= '0; m_en[2] <= '0;
      m_irq <= 1'b0; m_rd <= '0;
    end else begin
      m_irq <= m_req();
      if (bus_sel && !bus_wr) m_rd <= m_read(bus_addr);
      if (bus_sel && bus_wr) begin
        case (bus_addr[7:2])
          6'd4: m_en[1] <= m_en[1] | bus_wdata;
          6'd5: m_en[2] <= m_en[2] | bus_wdata;
          6'd6: m_en[0] <= m_en[0] | bus_wdata;
          6'd7: m_en[1] <= m_en[1] & ~bus_wdata;
          6'd8: m_en[2] <= m_en[2] & ~bus_wdata;
          6'd9: m_en[0] <= m_en[0] & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL %s irq_o actual %0b expected %0b", cur_req, irq_o, m_irq);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s bus_rdata actual %08h expected %08h", cur_req, bus_rdata, m_rd);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_src(logic [95:0] s);
    @(negedge clk);
    src_i = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      running = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1: reset state of outputs and masks
    cur_req = "R1";
    checks++;
    if (irq_o !== 1'b0 || bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 irq/rdata actual %0b/%08h expected 0/00000000", irq_o, bus_rdata);
    end
    running = 1'b1;
    rd_reg(8'h10); rd_reg(8'h14); rd_reg(8'h18);

    // R2: set only adds bits; R8: read back through both addresses
    cur_req = "R2";
    wr_reg(8'h10, 32'h0000_00F0);
    wr_reg(8'h10, 32'h0000_0F00);
    rd_reg(8'h10);
    cur_req = "R8";
    rd_reg(8'h1C);
    cur_req = "R2";
    wr_reg(8'h14, 32'h8000_0001);
    wr_reg(8'h18, 32'h0000_0003);
    rd_reg(8'h20); rd_reg(8'h24);

    // R4, R7: bank 1 and bank 2 pending under several patterns
    cur_req = "R4";
    set_src({32'h0, 32'h0000_0010, 32'h0});
    rd_reg(8'h04);
    cur_req = "R7";
    set_src({32'h0, 32'h0000_000F, 32'h0});
    idle(2);
    rd_reg(8'h04);
    cur_req = "R4";
    set_src({32'hFFFF_FFFF, 32'h0, 32'h0});
    rd_reg(8'h08);
    rd_reg(8'h09);

    // R5: summary bits against bank 0 content
    cur_req = "R5";
    set_src({32'h0000_0001, 32'h0000_0100, 32'h0000_0002});
    rd_reg(8'h00);
    set_src({32'h0, 32'h0000_0100, 32'h0000_0002});
    rd_reg(8'h00);

    // R6: bank 0 inputs 8 and 9 are ignored even when enabled
    cur_req = "R6";
    wr_reg(8'h18, 32'hFFFF_FFFF);
    set_src({32'h0, 32'h0, 32'h0000_0300});
    idle(2);
    rd_reg(8'h00);
    set_src({32'h0, 32'h0000_0080, 32'h0000_0300});
    rd_reg(8'h00);

    // R3: clear leaves zero bits alone, all ones masks everything
    cur_req = "R3";
    set_src({96{1'b1}});
    wr_reg(8'h1C, 32'h0000_0030);
    rd_reg(8'h10);
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    wr_reg(8'h20, 32'hFFFF_FFFF);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    idle(2);
    rd_reg(8'h10); rd_reg(8'h14); rd_reg(8'h18); rd_reg(8'h00);

    // R9: reserved and pending addresses hold no state
    cur_req = "R9";
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h3C, 32'hFFFF_FFFF);
    rd_reg(8'h0C); rd_reg(8'h3C); rd_reg(8'h10); rd_reg(8'h14); rd_reg(8'h18);
    wr_reg(8'h13, 32'h0000_0001);
    rd_reg(8'h11);

    // random mix of all operations
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      src_i = {$urandom(), $urandom(), $urandom()} & {3{$urandom() | $urandom()}};
      if ($urandom_range(0, 3) == 0) src_i = '0;
      bus_sel = ($urandom_range(0, 2) != 0);
      bus_wr = $urandom_range(0, 1);
      bus_addr = 8'($urandom_range(0, 11) * 4);
      bus_wdata = $urandom() & $urandom();
    end
    idle(3);
    finish_run();
  end
endmodule